// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Logic

This block keeps the per-vector bookkeeping for one local interrupt unit. It holds a 256-bit request set, a 256-bit in-service set and a 256-bit trigger-kind set. It also holds an 8-bit task priority and a 9-bit spurious/enable register. Interrupt sources post a vector through the request port and mark it as level or edge. The processor takes the most urgent vector with an acknowledge strobe and retires it with an end-of-interrupt strobe.

Vectors are ranked by their numeric value. A vector's priority class is its upper four bits. A request reaches the processor only when its class is strictly above the processor priority class. The processor priority is derived from the task priority and the most urgent vector in service. If an acknowledge arrives while the top request is held back, the block answers with the spurious vector and leaves its state alone. Retiring a level-triggered vector produces a broadcast pulse carrying that vector, so that upstream routing can re-arm the line. A configuration input suppresses this pulse.

Top module: `intr_prio_ack`

## Requirements
- R1: A request with `req_valid` sets the vector's request bit. It sets the vector's trigger bit when `req_level`=1 and clears that bit when `req_level`=0. The trigger bit is seen later through the retire broadcast.
- R2: `ppr_value` equals the task priority when the task class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise it equals that in-service class followed by four zero bits. An empty in-service set counts as class 0.
- R3: While bit 8 of the spurious register is 0, `irq_pending` is 0 and an acknowledge produces no response.
- R4: A request is blocked when the block is enabled, `ppr_value` is nonzero and the class of the highest request is less than or equal to the class of `ppr_value`. An acknowledge while blocked responds with bits 7:0 of the spurious register and changes no request or in-service bit.
- R5: An acknowledge while `irq_pending`=1 responds with the highest requested vector. That vector's request bit is cleared and its in-service bit is set.
- R6: End-of-interrupt clears the highest set in-service bit. It does nothing when the in-service set is empty.
- R7: `eoi_bcast` pulses with `eoi_bcast_vec` equal to the retired vector only when that vector's trigger bit is 1 and `eoi_suppress` is 0.
- R8: A write with `wr_svr` stores bits 8:0 of `wr_data` and discards the rest. A write with `wr_tpr` stores bits 7:0 as the task priority.
- R9: "Highest" always means the most significant set bit of the 256-bit set.
- R10: `irq_pending` is 1 exactly when the block is enabled, some request is set and the top request is not blocked. It reflects the state registered at the previous clock edge.
- R11: After reset, nothing is requested or in service, the task priority is 0, the spurious register is 0x0FF (disabled) and no pulse is driven.
- R12: `ack_resp_valid`/`ack_resp_vec` and `eoi_bcast`/`eoi_bcast_vec` are registered. They appear in the cycle after the strobe and last one cycle.
- R13: Within one cycle, the acknowledge and retire actions are taken from the state before the edge. A request arriving in the same cycle is applied after the acknowledge clears its bit, so a re-posted vector stays requested. An in-service bit being set by an acknowledge wins over a clear by the retire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Post a request this cycle |
| req_vector | input | 8 | Vector being posted |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_strobe | input | 1 | Processor acknowledge |
| ack_resp_valid | output | 1 | Acknowledge response present |
| ack_resp_vec | output | 8 | Vector returned by the acknowledge |
| eoi_strobe | input | 1 | End-of-interrupt |
| eoi_suppress | input | 1 | Suppress the retire broadcast |
| eoi_bcast | output | 1 | Retire broadcast pulse |
| eoi_bcast_vec | output | 8 | Vector of the broadcast |
| wr_tpr | input | 1 | Write task priority |
| wr_svr | input | 1 | Write spurious/enable register |
| wr_data | input | 32 | Write data |
| irq_pending | output | 1 | Deliverable interrupt present |
| ppr_value | output | 8 | Processor priority |
| svr_value | output | 9 | Spurious/enable register contents |

## Verification
The bench targets class-boundary cases: a request whose class equals the processor priority class must be blocked, and one class higher must be delivered. A design using a strict comparison would leak equal-class vectors. An acknowledge while blocked must return the spurious vector and leave the request intact. If it also moved the request, a later retire would broadcast a vector that was never serviced. Retire is exercised on an empty in-service set, on edge vectors, on level vectors with suppression, and in the same cycle as an acknowledge and a re-posted request. A design that applied these in a different order would lose a request or an in-service bit.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;

    localparam int unsigned VEC_COUNT = 256;
    localparam int unsigned VEC_W     = $clog2(VEC_COUNT);
    localparam int unsigned CLASS_LSB = 4;
    localparam int unsigned CLASS_W   = VEC_W - CLASS_LSB;
    localparam int unsigned SVR_W     = VEC_W + 1;
    localparam int unsigned SVR_EN    = SVR_W - 1;

    typedef logic [VEC_COUNT-1:0] vecset_t;
    typedef logic [VEC_W-1:0]     vec_t;

    typedef struct packed {
        vecset_t           irr;
        vecset_t           isr;
        vecset_t           tmr;
        vec_t              tpr;
        logic [SVR_W-1:0]  svr;
        logic              ack_v;
        vec_t              ack_vec;
        logic              bc_v;
        vec_t              bc_vec;
    } ipa_state_t;

endpackage

// File: rtl/msb_locate.sv
module msb_locate #(
    parameter int unsigned WIDTH = 256,
    parameter int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic             found,
    output logic [IDX_W-1:0] top_idx
);
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits_in[i]) begin
                top_idx = IDX_W'(i);
            end
        end
    end

    assign found = |bits_in;
endmodule

// File: rtl/ppr_calc.sv
module ppr_calc #(
    parameter int unsigned VW  = 8,
    parameter int unsigned CLS = 4
) (
    input  logic [VW-1:0] tpr,
    input  logic          isr_any,
    input  logic [VW-1:0] isr_top,
    output logic [VW-1:0] ppr
);
    localparam int unsigned CW = VW - CLS;

    logic [CW-1:0] tpr_cls;
    logic [CW-1:0] isr_cls;

    always_comb begin
        tpr_cls = tpr[VW-1:CLS];
        isr_cls = isr_any ? isr_top[VW-1:CLS] : '0;
        if (tpr_cls >= isr_cls) begin
            ppr = tpr;
        end else begin
            ppr = {isr_cls, {CLS{1'b0}}};
        end
    end
endmodule

// File: rtl/pend_eval.sv
module pend_eval #(
    parameter int unsigned VW  = 8,
    parameter int unsigned CLS = 4
) (
    input  logic          enabled,
    input  logic          irr_any,
    input  logic [VW-1:0] irr_top,
    input  logic [VW-1:0] ppr,
    output logic          deliver,
    output logic          blocked
);
    logic candidate;
    logic held;

    always_comb begin
        candidate = enabled && irr_any;
        held      = (ppr != '0) && (irr_top[VW-1:CLS] <= ppr[VW-1:CLS]);
        blocked   = candidate && held;
        deliver   = candidate && !held;
    end
endmodule

// File: rtl/intr_prio_ack.sv
module intr_prio_ack
    import intr_prio_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter logic [8:0]  SVR_RESET = 9'h0FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    input  logic              ack_strobe,
    output logic              ack_resp_valid,
    output logic [VEC_W-1:0]  ack_resp_vec,
    input  logic              eoi_strobe,
    input  logic              eoi_suppress,
    output logic              eoi_bcast,
    output logic [VEC_W-1:0]  eoi_bcast_vec,
    input  logic              wr_tpr,
    input  logic              wr_svr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq_pending,
    output logic [VEC_W-1:0]  ppr_value,
    output logic [SVR_W-1:0]  svr_value
);
    ipa_state_t state_q, state_d;

    logic       irr_any, isr_any;
    vec_t       irr_top, isr_top;
    vec_t       ppr;
    logic       deliver, blocked;
    vecset_t    irr_clr, isr_clr, isr_set;

    msb_locate #(.WIDTH(VEC_COUNT), .IDX_W(VEC_W)) u_irr_top (
        .bits_in (state_q.irr),
        .found   (irr_any),
        .top_idx (irr_top)
    );

    msb_locate #(.WIDTH(VEC_COUNT), .IDX_W(VEC_W)) u_isr_top (
        .bits_in (state_q.isr),
        .found   (isr_any),
        .top_idx (isr_top)
    );

    ppr_calc #(.VW(VEC_W), .CLS(CLASS_LSB)) u_ppr (
        .tpr     (state_q.tpr),
        .isr_any (isr_any),
        .isr_top (isr_top),
        .ppr     (ppr)
    );

    pend_eval #(.VW(VEC_W), .CLS(CLASS_LSB)) u_pend (
        .enabled (state_q.svr[SVR_EN]),
        .irr_any (irr_any),
        .irr_top (irr_top),
        .ppr     (ppr),
        .deliver (deliver),
        .blocked (blocked)
    );

    // Next-state: acknowledge and retire read the registered state; the
    // request port is merged after the acknowledge clear; set beats clear.
    always_comb begin
        state_d         = state_q;
        state_d.ack_v   = 1'b0;
        state_d.ack_vec = '0;
        state_d.bc_v    = 1'b0;
        state_d.bc_vec  = '0;
        irr_clr         = '0;
        isr_clr         = '0;
        isr_set         = '0;

        if (ack_strobe) begin
            if (deliver) begin
                irr_clr[irr_top] = 1'b1;
                isr_set[irr_top] = 1'b1;
                state_d.ack_v    = 1'b1;
                state_d.ack_vec  = irr_top;
            end else if (blocked) begin
                state_d.ack_v    = 1'b1;
                state_d.ack_vec  = state_q.svr[VEC_W-1:0];
            end
        end

        if (eoi_strobe && isr_any) begin
            isr_clr[isr_top] = 1'b1;
            if (state_q.tmr[isr_top] && !eoi_suppress) begin
                state_d.bc_v   = 1'b1;
                state_d.bc_vec = isr_top;
            end
        end

        state_d.irr = state_q.irr & ~irr_clr;
        if (req_valid) begin
            state_d.irr[req_vector] = 1'b1;
            state_d.tmr[req_vector] = req_level;
        end

        state_d.isr = (state_q.isr & ~isr_clr) | isr_set;

        if (wr_tpr) begin
            state_d.tpr = wr_data[VEC_W-1:0];
        end
        if (wr_svr) begin
            state_d.svr = wr_data[SVR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.svr     <= SVR_RESET;
        end else begin
            state_q         <= state_d;
        end
    end

    assign ack_resp_valid = state_q.ack_v;
    assign ack_resp_vec   = state_q.ack_vec;
    assign eoi_bcast      = state_q.bc_v;
    assign eoi_bcast_vec  = state_q.bc_vec;
    assign irq_pending    = deliver;
    assign ppr_value      = ppr;
    assign svr_value      = state_q.svr;
endmodule

// File: rtl/intr_prio_ack_chk.sv
module intr_prio_ack_chk
    import intr_prio_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_strobe,
    input logic              ack_resp_valid,
    input logic [VEC_W-1:0]  ack_resp_vec,
    input logic              eoi_strobe,
    input logic              eoi_suppress,
    input logic              eoi_bcast,
    input logic              wr_svr,
    input logic [DATA_W-1:0] wr_data,
    input logic              irq_pending,
    input logic [VEC_W-1:0]  ppr_value,
    input logic [SVR_W-1:0]  svr_value,
    input logic [VEC_W-1:0]  tpr_q
);
    // R3: no delivery while software-disabled
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !svr_value[SVR_EN] |-> !irq_pending);

    // R2: processor priority never drops below the task priority
    p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_value >= tpr_q);

    // R12: responses only follow a strobe
    p_ack_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_resp_valid |-> $past(ack_strobe));

    p_bcast_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi_strobe));

    // R7: suppression blocks the broadcast
    p_bcast_no_supp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> !$past(eoi_suppress));

    // R8: only nine bits kept on a write
    p_svr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_svr |=> svr_value == $past(wr_data[SVR_W-1:0]));

    // R4: a blocked acknowledge returns the spurious vector
    p_blocked_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_strobe && !irq_pending && svr_value[SVR_EN]) |=>
            (!ack_resp_valid || ack_resp_vec == $past(svr_value[VEC_W-1:0])));
endmodule

bind intr_prio_ack intr_prio_ack_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ack_strobe     (ack_strobe),
    .ack_resp_valid (ack_resp_valid),
    .ack_resp_vec   (ack_resp_vec),
    .eoi_strobe     (eoi_strobe),
    .eoi_suppress   (eoi_suppress),
    .eoi_bcast      (eoi_bcast),
    .wr_svr         (wr_svr),
    .wr_data        (wr_data),
    .irq_pending    (irq_pending),
    .ppr_value      (ppr_value),
    .svr_value      (svr_value),
    .tpr_q          (state_q.tpr)
);

// File: tb/tb_intr_prio_ack.sv
module tb_intr_prio_ack;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_level, ack_strobe, eoi_strobe, eoi_suppress;
    logic [7:0]  req_vector;
    logic        wr_tpr, wr_svr;
    logic [31:0] wr_data;
    logic        ack_resp_valid, eoi_bcast, irq_pending;
    logic [7:0]  ack_resp_vec, eoi_bcast_vec, ppr_value;
    logic [8:0]  svr_value;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [255:0] m_irr, m_isr, m_tmr;
    logic [7:0]   m_tpr;
    logic [8:0]   m_svr;

    always #10 clk = ~clk;

    intr_prio_ack dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .ack_strobe(ack_strobe), .ack_resp_valid(ack_resp_valid), .ack_resp_vec(ack_resp_vec),
        .eoi_strobe(eoi_strobe), .eoi_suppress(eoi_suppress),
        .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec),
        .wr_tpr(wr_tpr), .wr_svr(wr_svr), .wr_data(wr_data),
        .irq_pending(irq_pending), .ppr_value(ppr_value), .svr_value(svr_value)
    );

    function automatic int top_bit(logic [255:0] v);
        int r = -1;
        for (int i = 0; i < 256; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [7:0] calc_ppr(logic [7:0] tpr, logic [255:0] isr);
        int s = top_bit(isr);
        int ic = (s < 0) ? 0 : (s >> 4);
        int tc = int'(tpr[7:4]);
        return (tc >= ic) ? tpr : 8'(ic << 4);
    endfunction

    function automatic bit calc_blocked(logic [8:0] svr, logic [255:0] irr, logic [7:0] p);
        int t = top_bit(irr);
        return svr[8] && (t >= 0) && (p != 0) && ((t >> 4) <= int'(p[7:4]));
    endfunction

    function automatic bit calc_pend(logic [8:0] svr, logic [255:0] irr, logic [7:0] p);
        return svr[8] && (irr != 0) && !calc_blocked(svr, irr, p);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_vector = 0; req_level = 0; ack_strobe = 0;
        eoi_strobe = 0; eoi_suppress = 0; wr_tpr = 0; wr_svr = 0; wr_data = 0;
    endtask

    // One operation per cycle; inputs driven at negedge, results checked at the next negedge.
    task automatic apply(string tag, bit rv, bit [7:0] rvec, bit rl, bit ak, bit eo,
                         bit sup, bit wt, bit ws, bit [31:0] d);
        int it, st;
        logic [7:0] p;
        bit e_av = 0, e_bv = 0;
        logic [7:0] e_avec = 0, e_bvec = 0;
        logic [255:0] n_irr, n_isr, n_tmr;
        req_valid = rv; req_vector = rvec; req_level = rl; ack_strobe = ak;
        eoi_strobe = eo; eoi_suppress = sup; wr_tpr = wt; wr_svr = ws; wr_data = d;
        it = top_bit(m_irr); st = top_bit(m_isr); p = calc_ppr(m_tpr, m_isr);
        n_irr = m_irr; n_isr = m_isr; n_tmr = m_tmr;
        if (eo && st >= 0) begin
            n_isr[st] = 1'b0;
            if (m_tmr[st] && !sup) begin e_bv = 1; e_bvec = 8'(st); end
        end
        if (ak) begin
            if (calc_pend(m_svr, m_irr, p)) begin
                e_av = 1; e_avec = 8'(it); n_irr[it] = 1'b0; n_isr[it] = 1'b1;
            end else if (calc_blocked(m_svr, m_irr, p)) begin
                e_av = 1; e_avec = m_svr[7:0];
            end
        end
        if (rv) begin n_irr[rvec] = 1'b1; n_tmr[rvec] = rl; end
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        m_irr = n_irr; m_isr = n_isr; m_tmr = n_tmr;
        if (wt) m_tpr = d[7:0];
        if (ws) m_svr = d[8:0];
        check({tag, " ack_valid"}, int'(ack_resp_valid), int'(e_av));
        if (e_av) check({tag, " ack_vec"}, int'(ack_resp_vec), int'(e_avec));
        check({tag, " bcast"}, int'(eoi_bcast), int'(e_bv));
        if (e_bv) check({tag, " bcast_vec"}, int'(eoi_bcast_vec), int'(e_bvec));
        p = calc_ppr(m_tpr, m_isr);
        check({tag, " pending"}, int'(irq_pending), int'(calc_pend(m_svr, m_irr, p)));
        check({tag, " ppr"}, int'(ppr_value), int'(p));
        check({tag, " svr"}, int'(svr_value), int'(m_svr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        idle_inputs();
        rst_n = 0;
        m_irr = 0; m_isr = 0; m_tmr = 0; m_tpr = 0; m_svr = 9'h0FF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R11 reset state
        check("R11 pending", int'(irq_pending), 0);
        check("R11 ppr", int'(ppr_value), 0);
        check("R11 svr", int'(svr_value), 'h0FF);
        check("R11 ack", int'(ack_resp_valid), 0);
        check("R11 bcast", int'(eoi_bcast), 0);

        // R3 disabled: request is stored but not delivered, ack has no response
        apply("R3 req", 1, 8'h30, 0, 0, 0, 0, 0, 0, 0);
        apply("R3 ack", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R8 enable with wide data, only nine bits stay
        apply("R8 svr", 0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_F1EE);
        // R1/R9: level 0x90 above edge 0x45 and 0x30
        apply("R1 edge", 1, 8'h45, 0, 0, 0, 0, 0, 0, 0);
        apply("R1 level", 1, 8'h90, 1, 0, 0, 0, 0, 0, 0);
        apply("R5 R9 ack", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R4: 0x45 blocked by ppr 0x90, spurious returned, state unchanged
        apply("R4 ack", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        apply("R4 again", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R7: retire level vector broadcasts 0x90
        apply("R7 eoi", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        apply("R5 ack2", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R1 edge retire: no broadcast
        apply("R1 eoi edge", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R6 empty retire
        apply("R6 empty", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R2/R4 equal class boundary
        apply("R2 tpr", 0, 0, 0, 0, 0, 0, 1, 0, 32'h57);
        apply("R4 eqcls", 1, 8'h5F, 1, 0, 0, 0, 0, 0, 0);
        apply("R10 above", 1, 8'h60, 1, 0, 0, 0, 0, 0, 0);
        apply("R5 ack60", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R7 suppression
        apply("R7 supp", 0, 0, 0, 0, 1, 1, 0, 0, 0);
        // R13 same-cycle ack + re-post of same vector + retire of empty ISR
        apply("R13 tpr0", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        apply("R13 mix", 1, 8'h5F, 1, 1, 1, 0, 0, 0, 0);
        apply("R13 ack", 0, 0, 0, 1, 1, 0, 0, 0, 0);
        // R3 disable again
        apply("R3 off", 0, 0, 0, 0, 0, 0, 0, 1, 32'h0FF);
        apply("R3 ack2", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        apply("R8 on", 0, 0, 0, 0, 0, 0, 0, 1, 32'h1F0);

        // Random mix checked against the model (R5 R6 R7 R10 R12 R13)
        for (int n = 0; n < 600; n++) begin
            bit [31:0] r = $urandom;
            bit [31:0] x = $urandom;
            apply("RND R10",
                  r[0] | r[1], x[7:0], r[2], r[5:3] == 0 || r[4:3] == 1, r[8:6] == 0,
                  r[9] & r[10], r[13:11] == 0, r[18:14] == 0,
                  (r[18:14] == 0) ? {23'h0, (r[20:19] != 0), x[15:8]} : {24'h0, x[15:8]});
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule